// File: doc/BRIEF.md
# Pulse-Distance Remote Frame Decoder

This block turns a stream of run-length bytes from an infrared receiver front end into 32-bit remote-control codes. Bit 7 of each byte gives the line level: 1 is a mark (carrier present), 0 is a space. Bits 6:0 give the length of that stretch in sample ticks. One tick is about 42.7 us. Consecutive bytes at the same level are added into a single run before any decision is taken on that run.

For each packet the decoder first finds the long leader mark and then the leader space. It then reads 32 pulse-distance bits. Each bit is a short mark followed by a space whose length sets the bit value. The bits are placed least significant first.

When the mark that ends the 32nd space arrives, the decoder reports the code. The report is a valid strobe if the command byte matches its complement, and an error strobe if it does not. Any timing violation, or a packet end that comes too early, reports an all-ones code with the error strobe. After a report, the rest of the packet is ignored. Leader search restarts with the next packet-end strobe.

Top module: `nec_runlen_decoder`

## Requirements
- R1: An input byte is accepted on every cycle in which `in_valid` is high. Bit 7 = 1 marks carrier, bit 7 = 0 marks silence, and bits 6:0 hold the tick count. Consecutive accepted bytes of the same level are summed into one run before that run is compared with any limit.
- R2: The leader-mark accumulator holds 64 ticks after reset and after each packet end. A mark run is accepted as the leader when the total exceeds 80 at the first following space. Otherwise the accumulator is set to zero and the search continues.
- R3: After the leader mark, the space run must exceed 40 ticks when the next mark arrives. A shorter space zeroes the accumulator and the space search continues.
- R4: During data, a mark run longer than 26 ticks, judged when the next space arrives, is an error.
- R5: During data, a space run is judged when the next mark arrives. More than 53 ticks is an error. From 27 to 53 ticks decodes a 1. 26 ticks or fewer decodes a 0.
- R6: Data bits fill the code least significant bit first. The result is reported when the mark that ends the 32nd space arrives.
- R7: Every leader, timing or early-end error reports `code` = 0xFFFFFFFF together with `code_error`.
- R8: A decoded code is valid only when bits 23:16 XOR bits 31:24 equal 0xFF. Bits 15:0 are not examined. A failing code is reported as decoded, with `code_error`.
- R9: A packet end that arrives before 32 bits have been decoded, including before any leader, raises `code_error` with an all-ones code.
- R10: After a report, all bytes are ignored until the packet end. That packet end produces no second report and returns the decoder to leader search.
- R11: `code_valid` and `code_error` are one-cycle strobes in the cycle after the deciding input is accepted. The two never pulse together. `code` is 0 after reset and keeps its value between reports.
- R12: `in_ready` is high in every cycle, so no input byte is ever stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Run-length byte present |
| in_data | input | 8 | Bit 7 level (1 = mark), bits 6:0 tick count |
| in_ready | output | 1 | Byte accepted (always high) |
| pkt_end | input | 1 | End-of-packet strobe; the byte in the same cycle, if any, is the packet's last |
| code | output | 32 | Last reported code (all ones on error) |
| code_valid | output | 1 | One-cycle strobe: code passed the complement check |
| code_error | output | 1 | One-cycle strobe: decode error, early end or failed check |

## Verification
On every cycle, the checker confirms that the two strobes are exclusive and that `code` stays put between reports. It also confirms that a valid report always carries a matching command pair, that an overlong data mark or space, or a premature packet end, leads to an all-ones error report on the next cycle, and that nothing is reported while the rest of a packet is being skipped. Only the bench scenarios can show the things that need a whole byte sequence. These are the summing of split runs, the offset that applies only to the first leader attempt, the exact 80/40/26/53 boundaries, LSB-first bit order, and recovery to a clean decode after errors.

// File: rtl/nec_rl_pkg.sv
`timescale 1ns/1ps
package nec_rl_pkg;
   // Decoder phase: leader mark, leader space, data mark, data space, skip rest of packet
   typedef enum logic [2:0] {
      ST_LMARK  = 3'd0,
      ST_LSPACE = 3'd1,
      ST_DMARK  = 3'd2,
      ST_DSPACE = 3'd3,
      ST_DRAIN  = 3'd4
   } nec_state_e;

   // Run accumulator operation
   typedef enum logic [1:0] {
      ACC_HOLD = 2'd0,
      ACC_ADD  = 2'd1,
      ACC_LOAD = 2'd2
   } acc_op_e;
endpackage

// File: rtl/nec_rl_accum.sv
`timescale 1ns/1ps
module nec_rl_accum
   import nec_rl_pkg::*;
#(
   parameter int CNT_W   = 7,
   parameter int ACC_W   = 12,
   parameter int RST_VAL = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  acc_op_e          op,
   input  logic [ACC_W-1:0] ld_val,
   input  logic [CNT_W-1:0] add_val,
   output logic [ACC_W-1:0] acc
);
   localparam int SUM_W = ACC_W + 1;
   localparam logic [ACC_W-1:0] ACC_MAX = '1;
   localparam logic [ACC_W-1:0] ACC_RST = ACC_W'(RST_VAL);

   logic [SUM_W-1:0] sum;

   // saturating add so very long runs never wrap below a limit
   assign sum = {1'b0, acc} + {{(SUM_W-CNT_W){1'b0}}, add_val};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= ACC_RST;
      end else begin
         unique case (op)
            ACC_ADD:  acc <= sum[ACC_W] ? ACC_MAX : sum[ACC_W-1:0];
            ACC_LOAD: acc <= ld_val;
            default:  acc <= acc;
         endcase
      end
   end
endmodule

// File: rtl/nec_bit_shifter.sv
`timescale 1ns/1ps
module nec_bit_shifter #(
   parameter int NBITS = 32,
   localparam int CW   = $clog2(NBITS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             shift,
   input  logic             bit_in,
   output logic [NBITS-1:0] word_nxt,
   output logic [CW-1:0]    cnt
);
   logic [NBITS-1:0] word;

   // LSB-first: new bits enter at the top and move down, so the first bit ends at bit 0
   assign word_nxt = {bit_in, word[NBITS-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word <= '0;
         cnt  <= '0;
      end else if (clr) begin
         word <= '0;
         cnt  <= '0;
      end else if (shift) begin
         word <= word_nxt;
         cnt  <= cnt + CW'(1);
      end
   end
endmodule

// File: rtl/nec_cmd_check.sv
`timescale 1ns/1ps
module nec_cmd_check #(
   parameter bit CHECK_CMD = 1'b1
) (
   input  logic [15:0] pair,   // top two bytes of the code: inverted command, command
   output logic        ok
);
   generate
      if (CHECK_CMD) begin : g_check
         assign ok = ((pair[15:8] ^ pair[7:0]) == 8'hFF);
      end else begin : g_pass
         logic unused_pair;
         assign unused_pair = ^pair;
         assign ok = 1'b1 | unused_pair;
      end
   endgenerate
endmodule

// File: rtl/nec_runlen_decoder.sv
`timescale 1ns/1ps
module nec_runlen_decoder
   import nec_rl_pkg::*;
#(
   parameter int CNT_W          = 7,
   parameter int ACC_W          = 12,
   parameter int NBITS          = 32,
   parameter bit MARK_LVL       = 1'b1,
   parameter bit CHECK_CMD      = 1'b1,
   parameter int LEAD_OFS       = 64,
   parameter int LEAD_MARK_MIN  = 80,
   parameter int LEAD_SPACE_MIN = 40,
   parameter int MARK_MAX       = 26,
   parameter int SPACE_ONE_MIN  = 26,
   parameter int SPACE_MAX      = 53,
   localparam int IN_W          = CNT_W + 1,
   localparam int CW            = $clog2(NBITS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_data,
   output logic             in_ready,
   input  logic             pkt_end,
   output logic [NBITS-1:0] code,
   output logic             code_valid,
   output logic             code_error
);
   // elaboration-time parameter checks
   generate
      if (ACC_W <= CNT_W) begin : g_bad_accw
         $error("ACC_W must exceed CNT_W");
      end
      if (NBITS < 16) begin : g_bad_nbits
         $error("NBITS must be at least 16");
      end
      if (LEAD_OFS >= (1 << ACC_W) || SPACE_MAX >= (1 << ACC_W)) begin : g_bad_lim
         $error("limits do not fit in ACC_W");
      end
   endgenerate

   localparam logic [ACC_W-1:0] L_MARK  = ACC_W'(LEAD_MARK_MIN);
   localparam logic [ACC_W-1:0] L_SPACE = ACC_W'(LEAD_SPACE_MIN);
   localparam logic [ACC_W-1:0] D_MARK  = ACC_W'(MARK_MAX);
   localparam logic [ACC_W-1:0] D_ONE   = ACC_W'(SPACE_ONE_MIN);
   localparam logic [ACC_W-1:0] D_SPMAX = ACC_W'(SPACE_MAX);
   localparam logic [ACC_W-1:0] OFS     = ACC_W'(LEAD_OFS);
   localparam logic [CW-1:0]    LAST_BIT = CW'(NBITS - 1);

   nec_state_e        st, st_nxt;
   acc_op_e           acc_op;
   logic [ACC_W-1:0]  acc, acc_ld;
   logic              is_mark;
   logic [CNT_W-1:0]  run;
   logic [ACC_W-1:0]  run_ext;
   logic              sh_clr, sh_en, sh_bit;
   logic [NBITS-1:0]  word_nxt;
   logic [CW-1:0]     bit_cnt;
   logic              cmd_ok;
   logic              fin_ok, fin_err;

   assign in_ready = 1'b1;
   assign is_mark  = (in_data[CNT_W] == MARK_LVL);
   assign run      = in_data[CNT_W-1:0];
   assign run_ext  = {{(ACC_W-CNT_W){1'b0}}, run};

   nec_rl_accum #(
      .CNT_W   (CNT_W),
      .ACC_W   (ACC_W),
      .RST_VAL (LEAD_OFS)
   ) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (acc_op),
      .ld_val  (acc_ld),
      .add_val (run),
      .acc     (acc)
   );

   nec_bit_shifter #(
      .NBITS (NBITS)
   ) u_shf (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (sh_clr),
      .shift    (sh_en),
      .bit_in   (sh_bit),
      .word_nxt (word_nxt),
      .cnt      (bit_cnt)
   );

   nec_cmd_check #(
      .CHECK_CMD (CHECK_CMD)
   ) u_chk_cmd (
      .pair (word_nxt[NBITS-1 -: 16]),
      .ok   (cmd_ok)
   );

   // A run is judged only when a byte of the opposite level arrives,
   // so acc always holds the merged length of the run being closed.
   always_comb begin
      st_nxt  = st;
      acc_op  = ACC_HOLD;
      acc_ld  = '0;
      sh_clr  = 1'b0;
      sh_en   = 1'b0;
      sh_bit  = 1'b0;
      fin_ok  = 1'b0;
      fin_err = 1'b0;
      if (in_valid) begin
         unique case (st)
            ST_LMARK: begin
               if (is_mark) begin
                  acc_op = ACC_ADD;
               end else if (acc > L_MARK) begin
                  st_nxt = ST_LSPACE;
                  acc_op = ACC_LOAD;
                  acc_ld = run_ext;
               end else begin
                  acc_op = ACC_LOAD;
               end
            end
            ST_LSPACE: begin
               if (!is_mark) begin
                  acc_op = ACC_ADD;
               end else if (acc > L_SPACE) begin
                  st_nxt = ST_DMARK;
                  acc_op = ACC_LOAD;
                  acc_ld = run_ext;
                  sh_clr = 1'b1;
               end else begin
                  acc_op = ACC_LOAD;
               end
            end
            ST_DMARK: begin
               if (is_mark) begin
                  acc_op = ACC_ADD;
               end else if (acc > D_MARK) begin
                  fin_err = 1'b1;
               end else begin
                  st_nxt = ST_DSPACE;
                  acc_op = ACC_LOAD;
                  acc_ld = run_ext;
               end
            end
            ST_DSPACE: begin
               if (!is_mark) begin
                  acc_op = ACC_ADD;
               end else if (acc > D_SPMAX) begin
                  fin_err = 1'b1;
               end else begin
                  sh_en  = 1'b1;
                  sh_bit = (acc > D_ONE);
                  if (bit_cnt == LAST_BIT) begin
                     fin_ok = 1'b1;
                  end else begin
                     st_nxt = ST_DMARK;
                     acc_op = ACC_LOAD;
                     acc_ld = run_ext;
                  end
               end
            end
            default: ;
         endcase
      end
      if (fin_ok || fin_err) begin
         st_nxt = ST_DRAIN;
      end
      if (pkt_end) begin
         if (st != ST_DRAIN && !fin_ok && !fin_err) begin
            fin_err = 1'b1;
         end
         st_nxt = ST_LMARK;
         acc_op = ACC_LOAD;
         acc_ld = OFS;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_LMARK;
         code       <= '0;
         code_valid <= 1'b0;
         code_error <= 1'b0;
      end else begin
         st         <= st_nxt;
         code_valid <= fin_ok & cmd_ok;
         code_error <= fin_err | (fin_ok & ~cmd_ok);
         if (fin_err) begin
            code <= '1;
         end else if (fin_ok) begin
            code <= word_nxt;
         end
      end
   end
endmodule

// File: rtl/nec_rl_checker.sv
`timescale 1ns/1ps
module nec_rl_checker
   import nec_rl_pkg::*;
#(
   parameter int CNT_W     = 7,
   parameter int ACC_W     = 12,
   parameter int NBITS     = 32,
   parameter bit MARK_LVL  = 1'b1,
   parameter bit CHECK_CMD = 1'b1,
   parameter int MARK_MAX  = 26,
   parameter int SPACE_MAX = 53,
   localparam int CW       = $clog2(NBITS + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [CNT_W:0]   in_data,
   input logic             pkt_end,
   input logic [NBITS-1:0] code,
   input logic             code_valid,
   input logic             code_error,
   input nec_state_e       st,
   input logic [ACC_W-1:0] acc,
   input logic [CW-1:0]    bit_cnt
);
   logic pair_ok;
   logic byte_mark;
   assign pair_ok   = ((code[NBITS-1 -: 8] ^ code[NBITS-9 -: 8]) == 8'hFF);
   assign byte_mark = (in_data[CNT_W] == MARK_LVL);

   assert_long_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DMARK && in_valid && !byte_mark && acc > ACC_W'(MARK_MAX))
      |=> (code_error && (&code)));

   assert_long_space_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DSPACE && in_valid && byte_mark && acc > ACC_W'(SPACE_MAX))
      |=> (code_error && (&code)));

   assert_bit_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CW'(NBITS));

   assert_err_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      code_error |-> ((&code) || !pair_ok || !CHECK_CMD));

   assert_valid_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (code_valid && CHECK_CMD) |-> pair_ok);

   assert_early_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_end && !in_valid && st != ST_DRAIN) |=> (code_error && (&code)));

   assert_drain_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DRAIN && !pkt_end) |=> (!code_valid && !code_error));

   assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(code_valid && code_error));

   assert_code_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!code_valid && !code_error) |-> $stable(code));

   assert_valid_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      code_valid |=> !code_valid);
endmodule

bind nec_runlen_decoder nec_rl_checker #(
   .CNT_W     (CNT_W),
   .ACC_W     (ACC_W),
   .NBITS     (NBITS),
   .MARK_LVL  (MARK_LVL),
   .CHECK_CMD (CHECK_CMD),
   .MARK_MAX  (MARK_MAX),
   .SPACE_MAX (SPACE_MAX)
) u_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_data    (in_data),
   .pkt_end    (pkt_end),
   .code       (code),
   .code_valid (code_valid),
   .code_error (code_error),
   .st         (st),
   .acc        (acc),
   .bit_cnt    (bit_cnt)
);

// File: tb/tb_nec_runlen_decoder.sv
`timescale 1ns/1ps
module tb_nec_runlen_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        pkt_end = 1'b0;
   logic        in_ready;
   logic [31:0] code;
   logic        code_valid, code_error;

   int n_chk = 0;
   int n_fail = 0;
   int n_val = 0;
   int n_err = 0;
   logic [31:0] last_code = 32'h0;

   always #2.5 clk = ~clk;

   nec_runlen_decoder dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .in_ready   (in_ready),
      .pkt_end    (pkt_end),
      .code       (code),
      .code_valid (code_valid),
      .code_error (code_error)
   );

   // strobes last one full cycle, so each is seen at exactly one falling edge
   always @(negedge clk) begin
      if (code_valid) begin n_val++; last_code = code; end
      if (code_error) begin n_err++; last_code = code; end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put(input bit mark, input int ticks);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = {mark, 7'(ticks)};
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic end_pkt();
      @(negedge clk);
      pkt_end = 1'b1;
      @(negedge clk);
      pkt_end = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic send_bits(input logic [31:0] val, input int nb, input int mk,
                            input int zero, input int one);
      for (int i = 0; i < nb; i++) begin
         put(1'b1, mk);
         put(1'b0, val[i] ? one : zero);
      end
   endtask

   task automatic frame(input logic [31:0] val, input int mk, input int zero, input int one);
      send_bits(val, 32, mk, zero, one);
      put(1'b1, mk);   // closing mark ends the last space
   endtask

   task automatic expect_result(input string req, input int v0, input int e0,
                                input int dv, input int de, input logic [31:0] exp);
      repeat (2) @(negedge clk);
      chk({req, " valid count"}, 32'(n_val - v0), 32'(dv));
      chk({req, " error count"}, 32'(n_err - e0), 32'(de));
      chk({req, " code"}, last_code, exp);
   endtask

   task automatic t_reset();   // R11 R12
      chk("R11 reset code", code, 32'h0);
      chk("R11 reset strobes", {30'h0, code_valid, code_error}, 32'h0);
      chk("R12 ready", {31'h0, in_ready}, 32'h1);
   endtask

   task automatic t_basic();   // R1 split leader mark, R6 LSB first, R8 low half unchecked
      int v0 = n_val, e0 = n_err;
      put(1'b1, 60); put(1'b1, 45); put(1'b0, 105);
      frame(32'hB748_1234, 13, 13, 39);
      expect_result("R6 basic", v0, e0, 1, 0, 32'hB748_1234);
      end_pkt();
      chk("R10 no second report", 32'(n_val - v0 + n_err - e0), 32'd1);
   endtask

   task automatic t_boundary();   // R4 mark 26 ok, R5 space 26 -> 0, 53 -> 1
      int v0 = n_val, e0 = n_err;
      put(1'b1, 100); put(1'b0, 100);
      frame(32'h01FE_A55A, 26, 26, 53);
      expect_result("R5 boundary", v0, e0, 1, 0, 32'h01FE_A55A);
      end_pkt();
   endtask

   task automatic t_one_min();   // R5 space 27 -> 1
      int v0 = n_val, e0 = n_err;
      put(1'b1, 100); put(1'b0, 100);
      frame(32'hC33C_7E81, 13, 10, 27);
      expect_result("R5 space 27", v0, e0, 1, 0, 32'hC33C_7E81);
      end_pkt();
   endtask

   task automatic t_leader_retry();   // R2 R3 retries, R1 merged runs
      int v0 = n_val, e0 = n_err;
      put(1'b1, 10); put(1'b0, 20);      // 64+10 too short, zeroes
      put(1'b1, 60); put(1'b0, 20);      // 60, no offset now: too short
      put(1'b1, 50); put(1'b1, 40);      // 90 merged
      put(1'b0, 30); put(1'b1, 13);      // space 30 too short
      put(1'b0, 25); put(1'b0, 25);      // 50 merged
      frame(32'h6699_0F0F, 13, 13, 39);
      expect_result("R2 R3 retry", v0, e0, 1, 0, 32'h6699_0F0F);
      end_pkt();
   endtask

   task automatic t_offset_edges();   // R2 80 fails, 81 passes; R3 40 fails, 41 passes; R9
      int v0 = n_val, e0 = n_err;
      put(1'b1, 16); put(1'b0, 50);
      end_pkt();
      expect_result("R2 mark 80 rejected", v0, e0, 0, 1, 32'hFFFF_FFFF);
      v0 = n_val; e0 = n_err;
      put(1'b1, 17); put(1'b0, 40); put(1'b1, 13); put(1'b0, 41);
      frame(32'h00FF_C3C3, 13, 13, 39);
      expect_result("R3 space edges", v0, e0, 1, 0, 32'h00FF_C3C3);
      end_pkt();
   endtask

   task automatic t_pulse_err();   // R4 R7 R10
      int v0 = n_val, e0 = n_err;
      put(1'b1, 100); put(1'b0, 100);
      put(1'b1, 13); put(1'b0, 39);
      put(1'b1, 20); put(1'b1, 7); put(1'b0, 13);   // merged mark 27
      put(1'b1, 13); put(1'b0, 13); put(1'b1, 13);
      expect_result("R4 long mark", v0, e0, 0, 1, 32'hFFFF_FFFF);
      end_pkt();
      chk("R10 drained after error", 32'(n_err - e0), 32'd1);
   endtask

   task automatic t_space_err();   // R5 R7 R1
      int v0 = n_val, e0 = n_err;
      put(1'b1, 100); put(1'b0, 100);
      put(1'b1, 13); put(1'b0, 30); put(1'b0, 24); put(1'b1, 13);
      expect_result("R5 space 54", v0, e0, 0, 1, 32'hFFFF_FFFF);
      end_pkt();
   endtask

   task automatic t_cmd_fail();   // R8
      int v0 = n_val, e0 = n_err;
      put(1'b1, 100); put(1'b0, 100);
      frame(32'hB648_1234, 13, 13, 39);
      expect_result("R8 complement mismatch", v0, e0, 0, 1, 32'hB648_1234);
      end_pkt();
   endtask

   task automatic t_early_end();   // R9
      int v0 = n_val, e0 = n_err;
      put(1'b1, 100); put(1'b0, 100);
      send_bits(32'h0000_03FF, 10, 13, 13, 39);
      end_pkt();
      expect_result("R9 end after 10 bits", v0, e0, 0, 1, 32'hFFFF_FFFF);
      v0 = n_val; e0 = n_err;
      end_pkt();
      expect_result("R9 end before leader", v0, e0, 0, 1, 32'hFFFF_FFFF);
   endtask

   task automatic t_drain();   // R10 R11
      int v0 = n_val, e0 = n_err;
      put(1'b1, 100); put(1'b0, 100);
      frame(32'h55AA_1357, 13, 13, 39);
      put(1'b1, 100); put(1'b0, 100);          // second frame in same packet ignored
      frame(32'h10EF_0000, 13, 13, 39);
      repeat (5) @(negedge clk);
      chk("R11 code held", code, 32'h55AA_1357);
      end_pkt();
      expect_result("R10 skip rest", v0, e0, 1, 0, 32'h55AA_1357);
      v0 = n_val; e0 = n_err;
      put(1'b1, 100); put(1'b0, 100);
      frame(32'h23DC_BEEF, 13, 13, 39);
      expect_result("R10 next packet decodes", v0, e0, 1, 0, 32'h23DC_BEEF);
      end_pkt();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_basic();
      t_boundary();
      t_one_min();
      t_leader_retry();
      t_offset_edges();
      t_pulse_err();
      t_space_err();
      t_cmd_fail();
      t_early_end();
      t_drain();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule